// File: doc/BRIEF.md
# Three-Wire SPI Master with Sticky Status Flags

This block is a byte-oriented SPI master that drives a serial clock and a data-out line and samples a data-in line. Software reaches it through a small register bus with two locations: a control/status byte and a data byte. Writing the data location places a byte in a single-entry transmit holding buffer. When the block is enabled and the shifter is idle, the held byte moves into the shift register and an 8-bit transfer runs. Each transfer sends the most significant bit first, at one quarter of the system clock rate.

The control/status byte holds the enable bit, a slave-select mode field, a read-only buffer-empty indication and three event flags. The flags mark a finished transfer, a data write that arrived while a transfer was running, and a mode fault. Hardware only sets these flags and software only clears them. Any flag that is set raises the single interrupt output while the interrupt enable input is high. Reading the data location returns the byte received by the most recent transfer.

Top module: `spi_xfer_master`

## Requirements
- R1: After reset the control/status byte (bus_sel = 0) reads 8'h06: mode field bits [3:2] = 01, buffer-empty bit [1] = 1, all other bits 0. After reset irq, sck and mosi are 0.
- R2: The enable bit is bit 0 of the control/status byte. While it is 0, no transfer starts and a held byte stays in the buffer, so bit 1 stays 0 and sck does not toggle. Setting the bit releases the held byte.
- R3: A data write (bus_wr with bus_sel = 1) on clock edge T clears the buffer-empty bit (bit 1) after T. If the block is enabled and idle, the byte moves into the shifter on edge T+1, and the bit reads 1 again after T+1.
- R4: A transfer sends 8 bits MSB first. Each bit period lasts 4 clocks: sck is low for 2 clocks, then high for 2. sck idles low. mosi changes only while sck falls, and miso is sampled when sck rises.
- R5: The transfer-complete flag (bit 7) sets on edge T+33 for a data write on edge T into an idle, enabled block. From that same edge, the data location (bus_sel = 1) returns the received byte.
- R6: A data write while a transfer is running sets the write-collision flag (bit 6). The written byte is discarded, and neither the running transfer nor the buffer changes.
- R7: The mode-fault flag (bit 5) sets when ss_n is sampled low while the enable bit is 1 and the mode field [3:2] is 01. With the mode field at 00, ss_n has no effect.
- R8: Flags in bits 7:5 are sticky. A control write with 0 in a flag bit clears that flag, and a 1 leaves it unchanged. A hardware set on the same edge wins over the clear.
- R9: irq is high exactly when irq_en is high and at least one of bits 7:5 is set.
- R10: Bit 4 always reads 0 and writes to it are ignored. Bits 3:2 and bit 0 read back as written.
- R11: A data write on the same edge that the held byte moves into the shifter is kept in the buffer without a collision. That byte is sent right after the current transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | Register select: 0 control/status, 1 data |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for the selected location |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |
| ss_n | input | 1 | Slave-select line, sampled for mode-fault detection |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The assertions assume that bus_wr, bus_sel, bus_wdata, ss_n and miso change only between clock edges and hold steady across each rising edge. They also assume that miso is settled before each rising edge of sck. The bench changes every input on the falling clock edge or one nanosecond after a rising edge. Its slave model moves miso only on falling sck, which happens right after a rising system clock edge, so miso has more than a full clock to settle before it is sampled. ss_n is driven low only in the mode-fault test and is returned high before transfers continue.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_DATA = 1'b1
    } sel_e;

    // control/status byte layout, bit 7 first
    typedef struct packed {
        logic       done_f;
        logic       coll_f;
        logic       fault_f;
        logic       rsvd;
        logic [1:0] ss_mode;
        logic       tx_empty;
        logic       enable;
    } ctrl_t;

    typedef struct packed {
        logic done;
        logic coll;
        logic fault;
    } evt_t;

    localparam logic [1:0] SSM_3WIRE = 2'b00;
    localparam logic [1:0] SSM_FAULT = 2'b01;

    function automatic logic any_flag(input ctrl_t c);
        return c.done_f | c.coll_f | c.fault_f;
    endfunction

endpackage

// File: rtl/spi_xfer_txbuf.sv
module spi_xfer_txbuf
    import spi_xfer_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         put,
    input  logic [W-1:0] put_data,
    input  logic         take,
    output logic         full,
    output logic [W-1:0] data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else if (put) begin
            full <= 1'b1;
            data <= put_data;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    // R3: a byte that was put is visible as held on the next cycle
    a_r3_put_fills: assert property (@(posedge clk) disable iff (rst)
        put |=> full);

    // R11: a put on the take edge keeps the buffer full
    a_r11_put_over_take: assert property (@(posedge clk) disable iff (rst)
        (put && take) |=> (full && data == $past(put_data)));

endmodule

// File: rtl/spi_xfer_shifter.sv
module spi_xfer_shifter
    import spi_xfer_pkg::*;
#(
    parameter int W       = BYTE_W,
    parameter int CLK_DIV = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] start_data,
    input  logic         miso,
    output logic         busy,
    output logic         done,
    output logic         sck,
    output logic         mosi,
    output logic [W-1:0] rx_data
);

    localparam int DIV_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam int BIT_W = (W > 2) ? $clog2(W) : 1;
    localparam logic [DIV_W-1:0] HALF     = DIV_W'(CLK_DIV / 2);
    localparam logic [DIV_W-1:0] SAMPLE_P = DIV_W'(CLK_DIV / 2 - 1);
    localparam logic [DIV_W-1:0] LAST_P   = DIV_W'(CLK_DIV - 1);
    localparam logic [BIT_W-1:0] LAST_B   = BIT_W'(W - 1);

    logic [DIV_W-1:0] div_cnt;
    logic [BIT_W-1:0] bit_cnt;
    logic [W-1:0]     tx_sh;
    logic [W-1:0]     rx_sh;
    logic             rise_ev;
    logic             fall_ev;

    assign rise_ev = busy && (div_cnt == SAMPLE_P);
    assign fall_ev = busy && (div_cnt == LAST_P);
    assign done    = fall_ev && (bit_cnt == LAST_B);
    assign sck     = busy && (div_cnt >= HALF);
    assign mosi    = busy && tx_sh[W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            rx_data <= '0;
        end else if (start && !busy) begin
            busy    <= 1'b1;
            div_cnt <= '0;
            bit_cnt <= '0;
            tx_sh   <= start_data;
        end else if (busy) begin
            div_cnt <= (div_cnt == LAST_P) ? '0 : div_cnt + 1'b1;
            if (rise_ev)
                rx_sh <= {rx_sh[W-2:0], miso};
            if (fall_ev) begin
                tx_sh   <= {tx_sh[W-2:0], 1'b0};
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (done) begin
                busy    <= 1'b0;
                rx_data <= rx_sh;
            end
        end
    end

    // R4: serial clock idles low outside a transfer
    a_r4_sck_idle_low: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sck);

    // R4: data out moves only at the start of a bit period
    a_r4_mosi_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && div_cnt != '0) |-> $stable(mosi));

    // R5: received byte changes only on a completion edge
    a_r5_rx_on_done: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(rx_data));

endmodule

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
    import spi_xfer_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ctrl_wr,
    input  logic [7:0]  wdata,
    input  evt_t        evt,
    input  logic        tx_empty,
    output ctrl_t       status
);

    logic       en_q;
    logic [1:0] mode_q;
    logic [2:0] flag_q;
    logic [2:0] keep_mask;
    logic [2:0] hw_set;
    logic       unused_wbits;

    assign unused_wbits = wdata[4] ^ wdata[1];
    assign keep_mask    = ctrl_wr ? wdata[7:5] : 3'b111;
    assign hw_set       = {evt.done, evt.coll, evt.fault};

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            mode_q <= SSM_FAULT;
            flag_q <= '0;
        end else begin
            flag_q <= hw_set | (flag_q & keep_mask);
            if (ctrl_wr) begin
                en_q   <= wdata[0];
                mode_q <= wdata[3:2];
            end
        end
    end

    always_comb begin
        status          = '0;
        status.done_f   = flag_q[2];
        status.coll_f   = flag_q[1];
        status.fault_f  = flag_q[0];
        status.rsvd     = 1'b0;
        status.ss_mode  = mode_q;
        status.tx_empty = tx_empty;
        status.enable   = en_q;
    end

    // R8: completion flag survives unless software writes a 0 to it
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
        (status.done_f && !(ctrl_wr && !wdata[7])) |=> status.done_f);

    // R6: a collision event always leaves its flag set
    a_r6_coll_sets: assert property (@(posedge clk) disable iff (rst)
        evt.coll |=> status.coll_f);

    // R7: a fault event always leaves its flag set
    a_r7_fault_sets: assert property (@(posedge clk) disable iff (rst)
        evt.fault |=> status.fault_f);

    // R10: reserved bit never reads 1
    a_r10_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        !status.rsvd);

endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
    import spi_xfer_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic       bus_sel,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       irq_en,
    output logic       irq,
    input  logic       ss_n,
    output logic       sck,
    output logic       mosi,
    input  logic       miso
);

    ctrl_t             status;
    evt_t              evt;
    logic              busy;
    logic              done;
    logic              data_wr;
    logic              buf_put;
    logic              buf_full;
    logic              start;
    logic [BYTE_W-1:0] buf_data;
    logic [BYTE_W-1:0] rx_data;
    sel_e              sel;

    assign sel       = sel_e'(bus_sel);
    assign data_wr   = bus_wr && (sel == SEL_DATA);
    assign buf_put   = data_wr && !busy;
    assign start     = status.enable && buf_full && !busy;

    assign evt.done  = done;
    assign evt.coll  = data_wr && busy;
    assign evt.fault = status.enable && (status.ss_mode == SSM_FAULT) && !ss_n;

    assign bus_rdata = (sel == SEL_DATA) ? rx_data : status;
    assign irq       = irq_en && any_flag(status);

    spi_xfer_txbuf #(.W(BYTE_W)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .put      (buf_put),
        .put_data (bus_wdata),
        .take     (start),
        .full     (buf_full),
        .data     (buf_data)
    );

    spi_xfer_shifter #(.W(BYTE_W), .CLK_DIV(CLK_DIV)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_data (buf_data),
        .miso       (miso),
        .busy       (busy),
        .done       (done),
        .sck        (sck),
        .mosi       (mosi),
        .rx_data    (rx_data)
    );

    spi_xfer_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ctrl_wr  (bus_wr && (sel == SEL_CTRL)),
        .wdata    (bus_wdata),
        .evt      (evt),
        .tx_empty (!buf_full),
        .status   (status)
    );

    // R2: no transfer begins while disabled
    a_r2_no_start_disabled: assert property (@(posedge clk) disable iff (rst)
        !status.enable |=> !$rose(busy));

    // R3: buffer-empty drops after an accepted data write
    a_r3_empty_clears: assert property (@(posedge clk) disable iff (rst)
        buf_put |=> !status.tx_empty);

    // R6: a colliding write leaves the buffer untouched
    a_r6_buf_kept: assert property (@(posedge clk) disable iff (rst)
        evt.coll |=> ($stable(buf_data) && $stable(buf_full)));

    // R9: interrupt follows enable and flags
    a_r9_irq_follows: assert property (@(posedge clk) disable iff (rst)
        (irq_en && status.done_f) |-> irq);

endmodule

// File: tb/sim_spi_xfer_master.sv
`timescale 1ns/1ps
module sim_spi_xfer_master;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_sel = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_en = 1'b1;
    logic       irq;
    logic       ss_n = 1'b1;
    logic       sck;
    logic       mosi;
    logic       miso = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0]  slv = '0;
    logic [15:0] cap = '0;
    int          sck_rises = 0;

    always #2 clk = ~clk;

    spi_xfer_master u0 (.*);

    // slave model: shift out on falling sck, capture mosi on rising sck
    always @(negedge sck) begin
        slv  = {slv[6:0], slv[7]};
        miso = slv[7];
    end
    always @(posedge sck) begin
        cap = {cap[14:0], mosi};
        sck_rises++;
    end

    // {tx byte, slave byte}
    localparam logic [15:0] VEC [6] = '{16'hA53C, 16'h00FF, 16'hFF00,
                                        16'h8001, 16'h7E81, 16'h1234};

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; bus_sel = 1'b0;
    endtask

    task automatic rd_data(output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1;
        #0.5;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic set_slave(input logic [7:0] v);
        slv = v; miso = v[7];
    endtask

    task automatic wait_done();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (bus_rdata[7]) break;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int e0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R1 status", 16'(bus_rdata), 16'h06);
        chk("R1 irq/sck/mosi", {13'b0, irq, sck, mosi}, 16'h0);

        // R10: reserved bit ignored, mode field and enable read back
        wr(0, 8'h18);
        @(negedge clk);
        chk("R10 readback", 16'(bus_rdata), 16'h0A);

        // R2: disabled, byte held
        wr(0, 8'h00);
        e0 = sck_rises;
        wr(1, 8'h5A);
        repeat (40) @(negedge clk);
        chk("R2 no sck", 16'(sck_rises - e0), 16'd0);
        chk("R2 held", 16'(bus_rdata[1]), 16'h0);
        set_slave(8'hC3);
        wr(0, 8'h01);
        wait_done();
        chk("R2 released", 16'(cap[7:0]), 16'h5A);

        // vector table
        for (int v = 0; v < 6; v++) begin
            set_slave(VEC[v][7:0]);
            wr(0, 8'h01);
            e0 = sck_rises;
            wr(1, VEC[v][15:8]);
            wait_done();
            chk("R4 mosi byte", 16'(cap[7:0]), 16'(VEC[v][15:8]));
            chk("R4 8 sck", 16'(sck_rises - e0), 16'd8);
            rd_data(d);
            chk("R5 rx byte", 16'(d), 16'(VEC[v][7:0]));
            chk("R9 irq", 16'(irq), 16'h1);
        end

        // R3/R5 exact timing
        set_slave(8'h69);
        wr(0, 8'h01);
        wr(1, 8'h96);
        @(negedge clk);
        chk("R3 empty low after T", 16'(bus_rdata[1]), 16'h0);
        @(negedge clk);
        chk("R3 empty high after T+1", 16'(bus_rdata[1]), 16'h1);
        repeat (31) @(negedge clk);
        chk("R5 not done at T+32", 16'(bus_rdata[7]), 16'h0);
        @(negedge clk);
        chk("R5 done at T+33", 16'(bus_rdata[7]), 16'h1);
        bus_sel = 1'b1; #0.5;
        chk("R5 rx at T+33", 16'(bus_rdata), 16'h69);
        bus_sel = 1'b0;

        // R8 sticky: writing ones keeps flags, zeros clear
        wr(0, 8'hE1);
        @(negedge clk);
        chk("R8 ones keep", 16'(bus_rdata[7]), 16'h1);
        irq_en = 1'b0;
        #0.5;
        chk("R9 irq masked", 16'(irq), 16'h0);
        irq_en = 1'b1;
        wr(0, 8'h01);
        @(negedge clk);
        chk("R8 cleared", 16'(bus_rdata[7:5]), 16'h0);
        chk("R9 irq low", 16'(irq), 16'h0);

        // R6 collision
        set_slave(8'h3C);
        e0 = sck_rises;
        wr(1, 8'hC6);
        repeat (5) @(negedge clk);
        wr(1, 8'hAA);
        @(negedge clk);
        chk("R6 coll flag", 16'(bus_rdata[6]), 16'h1);
        chk("R6 irq", 16'(irq), 16'h1);
        wait_done();
        chk("R6 transfer intact", 16'(cap[7:0]), 16'hC6);
        repeat (50) @(negedge clk);
        chk("R6 discarded, no second byte", 16'(sck_rises - e0), 16'd8);
        chk("R6 buffer empty", 16'(bus_rdata[1]), 16'h1);

        // R11 write on the take edge
        wr(0, 8'h01);
        e0 = sck_rises;
        set_slave(8'h11);
        wr(1, 8'hB4);
        wr(1, 8'h4B);
        @(negedge clk);
        chk("R11 no coll", 16'(bus_rdata[6]), 16'h0);
        chk("R11 held", 16'(bus_rdata[1]), 16'h0);
        repeat (80) @(negedge clk);
        chk("R11 both bytes", cap, 16'hB44B);
        chk("R11 16 sck", 16'(sck_rises - e0), 16'd16);

        // R7 mode fault
        wr(0, 8'h01);
        ss_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 mode 00 no fault", 16'(bus_rdata[5]), 16'h0);
        wr(0, 8'h05);
        repeat (2) @(negedge clk);
        chk("R7 fault set", 16'(bus_rdata[5]), 16'h1);
        ss_n = 1'b1;
        wr(0, 8'h01);
        @(negedge clk);
        chk("R7 fault cleared", 16'(bus_rdata[5]), 16'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule